// File: doc/BRIEF.md
# Programmable Time Tag Counter

This block keeps a 16-bit time tag that advances at a selectable rate and can be read and overwritten by the host at any time. A prescaler turns the system clock (16 MHz or 12 MHz, chosen by an input) into a 1 µs base. A second divider turns that base into counter steps of 2, 4, 8, 16, 32 or 64 µs. Instead of the internal rate, the counter can follow rising edges of an external oscillator input, follow software step strobes for self-test, or stay frozen.

Protocol logic elsewhere decodes synchronize mode commands and signals them to the block as strobes. A synchronize without data can clear the count, and a synchronize with data can load the received word. Each of these actions has its own enable. When the counter advances from 0xFFFF to 0x0000, a sticky rollover flag is set, and an interrupt request follows it while the interrupt is enabled. A message-start strobe copies the current count into a tag register, which the message logic stores as the message's time tag word. At 2 µs per step the counter wraps about every 131 ms, and at 64 µs per step about every 4.2 s.

Top module: `ttag_counter`

## Requirements
- R1: After reset, `count`, `tag_word`, `ro_flag` and `irq` are all zero.
- R2: A cycle with `wr_en` high loads `wr_data` into `count` at that clock edge. The same write restarts both prescaler stages, so the first internal step comes exactly DIV×L cycles after the write edge.
- R3: With `src_sel`=0 the counter advances once every DIV×L clock cycles. DIV is 16 when `clk_sel_slow`=0 and 12 when it is 1. L is 2<<`res_sel` µs for codes 0..5, and codes 6 and 7 behave as code 5 (64 µs).
- R4: With `src_sel`=1, each rising edge of `ext_tick` advances the counter by one. The input passes through a two-stage synchronizer, so the count changes at the third clock edge after `ext_tick` is first sampled high.
- R5: With `src_sel`=2, each cycle in which `sw_step` is high advances the counter by one at that edge. In every other mode `sw_step` has no effect.
- R6: With `src_sel`=3 the counter holds its value. Only a write or a synchronize action changes it.
- R7: `sync_nodata` clears the counter when `sync_clr_en` is 1 and is ignored when it is 0.
- R8: `sync_data` loads `sync_word` when `sync_load_en` is 1 and is ignored when it is 0.
- R9: Priority among actions in one cycle: host write, then synchronize clear, then synchronize load, then an advance.
- R10: Only an advance from 0xFFFF to 0x0000 sets `ro_flag`; a write or synchronize action that results in zero does not. The flag stays set until `ro_clr` is high. If a wrap and `ro_clr` fall in the same cycle, the flag is set.
- R11: `irq` is high exactly when `ro_flag` is set and `irq_en` is 1.
- R12: `msg_start` copies the count present before the edge into `tag_word` at that edge. At all other times `tag_word` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_sel_slow | input | 1 | 0: 16 cycles per µs, 1: 12 cycles per µs |
| res_sel | input | 3 | Step size code, 2<<code µs (codes above 5 behave as 5) |
| src_sel | input | 2 | 0 internal, 1 external, 2 software, 3 hold |
| ext_tick | input | 1 | External oscillator input |
| sw_step | input | 1 | Software step strobe |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 16 | Host write value |
| sync_nodata | input | 1 | Synchronize-without-data strobe |
| sync_data | input | 1 | Synchronize-with-data strobe |
| sync_word | input | 16 | Data word received with the synchronize |
| sync_clr_en | input | 1 | Enables clear on synchronize without data |
| sync_load_en | input | 1 | Enables load on synchronize with data |
| irq_en | input | 1 | Rollover interrupt enable |
| ro_clr | input | 1 | Clears the rollover flag |
| msg_start | input | 1 | Message start strobe |
| count | output | 16 | Current time tag value |
| tag_word | output | 16 | Count captured at the last message start |
| ro_flag | output | 1 | Sticky rollover status |
| irq | output | 1 | Rollover interrupt request |

## Verification
The hardest situation to reach from the ports is a wrap that coincides with a competing action: a write, a synchronize clear or load, or a flag clear in the same cycle. Reaching it through internal ticks would take up to 65536 steps of as many as 1024 cycles each. The stimulus avoids that by working in software-step mode, where host writes often preload values just below 0xFFFF, and randomly overlapping strobes then drive the counter across the wrap many times per run. Directed runs from a write of 0xFFFF reach the internal-tick wrap within one step period.

// File: rtl/ttag_counter.sv
module ttag_counter #(
  parameter int CNT_W    = 16,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 12,
  parameter int RES_MAX  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_sel_slow,
  input  logic [2:0]       res_sel,
  input  logic [1:0]       src_sel,
  input  logic             ext_tick,
  input  logic             sw_step,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             sync_nodata,
  input  logic             sync_data,
  input  logic [CNT_W-1:0] sync_word,
  input  logic             sync_clr_en,
  input  logic             sync_load_en,
  input  logic             irq_en,
  input  logic             ro_clr,
  input  logic             msg_start,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] tag_word,
  output logic             ro_flag,
  output logic             irq
);
  localparam int MAX_DIV = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int DIV_W   = $clog2(MAX_DIV);
  localparam int RES_W   = RES_MAX + 1;

  logic [DIV_W-1:0] us_cnt, div_last;
  logic [RES_W-1:0] res_cnt, res_last;
  logic [RES_W:0]   res_lim;
  logic [2:0]       rs;
  logic [2:0]       ext_sh;
  logic             us_tick, int_tick, ext_rise, advance, do_clr, do_load, wrap;

  assign div_last = clk_sel_slow ? DIV_W'(SLOW_DIV - 1) : DIV_W'(FAST_DIV - 1);
  assign us_tick  = (us_cnt == div_last);
  assign rs       = (res_sel > 3'(RES_MAX)) ? 3'(RES_MAX) : res_sel;
  assign res_lim  = (RES_W+1)'(1) << (rs + 3'd1);
  assign res_last = res_lim[RES_W-1:0] - 1'b1;
  assign int_tick = us_tick && (res_cnt >= res_last);
  assign ext_rise = ext_sh[1] && !ext_sh[2];

  assign advance = (src_sel == 2'd0 && int_tick) ||
                   (src_sel == 2'd1 && ext_rise) ||
                   (src_sel == 2'd2 && sw_step);
  assign do_clr  = sync_nodata && sync_clr_en;
  assign do_load = sync_data && sync_load_en;
  assign wrap    = advance && !wr_en && !do_clr && !do_load && (count == '1);
  assign irq     = ro_flag && irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n || wr_en) begin
      us_cnt  <= '0;
      res_cnt <= '0;
    end else if (us_tick) begin
      us_cnt  <= '0;
      res_cnt <= (res_cnt >= res_last) ? '0 : res_cnt + 1'b1;
    end else begin
      us_cnt  <= us_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ext_sh <= '0;
    else        ext_sh <= {ext_sh[1:0], ext_tick};
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (wr_en)   count <= wr_data;
    else if (do_clr)  count <= '0;
    else if (do_load) count <= sync_word;
    else if (advance) count <= count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ro_flag <= 1'b0;
    else if (wrap)   ro_flag <= 1'b1;
    else if (ro_clr) ro_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         tag_word <= '0;
    else if (msg_start) tag_word <= count;
  end
endmodule

// File: rtl/ttag_counter_chk.sv
module ttag_counter_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       src_sel,
  input logic             wr_en,
  input logic [CNT_W-1:0] wr_data,
  input logic             sync_nodata,
  input logic             sync_data,
  input logic             sync_clr_en,
  input logic             sync_load_en,
  input logic [CNT_W-1:0] sync_word,
  input logic             irq_en,
  input logic             msg_start,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] tag_word,
  input logic             ro_flag,
  input logic             irq
);
  p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> count == $past(wr_data));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3 && !wr_en && !sync_nodata && !sync_data) |=> $stable(count));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && sync_nodata && sync_clr_en) |=> count == '0);

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(sync_nodata && sync_clr_en) && sync_data && sync_load_en) |=> count == $past(sync_word));

  p_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sync_nodata && !sync_data) |=> (count == $past(count) || count == $past(count) + 1'b1));

  p_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ro_flag) |-> count == '0);

  p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_en && ro_flag));

  p_tag_r12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start |=> tag_word == $past(count));
endmodule

bind ttag_counter ttag_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .wr_en(wr_en), .wr_data(wr_data),
  .sync_nodata(sync_nodata), .sync_data(sync_data), .sync_clr_en(sync_clr_en),
  .sync_load_en(sync_load_en), .sync_word(sync_word), .irq_en(irq_en),
  .msg_start(msg_start), .count(count), .tag_word(tag_word), .ro_flag(ro_flag), .irq(irq)
);

// File: tb/tb_ttag_counter.sv
module tb_ttag_counter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic clk_sel_slow = 1'b0, ext_tick = 1'b0, sw_step = 1'b0, wr_en = 1'b0;
  logic [2:0] res_sel = 3'd0;
  logic [1:0] src_sel = 2'd3;
  logic [15:0] wr_data = '0, sync_word = '0;
  logic sync_nodata = 0, sync_data = 0, sync_clr_en = 0, sync_load_en = 0;
  logic irq_en = 0, ro_clr = 0, msg_start = 0;
  logic [15:0] count, tag_word;
  logic ro_flag, irq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ttag_counter dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic host_write(logic [15:0] v);
    @(negedge clk); wr_en = 1; wr_data = v;
    @(negedge clk); wr_en = 0;
  endtask

  function automatic logic [15:0] model_next(logic [15:0] c, logic w, logic [15:0] wd,
      logic snd, logic cen, logic sd, logic len, logic [15:0] sw, logic adv);
    if (w) return wd;
    if (snd && cen) return 16'h0;
    if (sd && len) return sw;
    if (adv) return c + 16'd1;
    return c;
  endfunction

  task automatic rate_test(string req, logic slow, logic [2:0] code);
    int period;
    int l;
    l = 2 << ((code > 3'd5) ? 5 : code);
    period = (slow ? 12 : 16) * l;
    src_sel = 2'd0; clk_sel_slow = slow; res_sel = code;
    host_write(16'h1230);
    repeat (period - 1) @(negedge clk);
    chk(req, count, 16'h1230);
    @(negedge clk);
    chk(req, count, 16'h1231);
    repeat (period) @(negedge clk);
    chk(req, count, 16'h1232);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] exp_c, exp_t;
    logic exp_f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 count", count, 0); chk("R1 tag", tag_word, 0);
    chk("R1 flag", {15'd0, ro_flag}, 0); chk("R1 irq", {15'd0, irq}, 0);

    // R2/R3 internal rates
    rate_test("R2 R3 16MHz 2us", 1'b0, 3'd0);
    rate_test("R3 12MHz 4us", 1'b1, 3'd1);
    rate_test("R3 12MHz 64us", 1'b1, 3'd5);
    rate_test("R3 code7 as 64us", 1'b0, 3'd7);

    // R10 R11 rollover via internal tick
    irq_en = 1; res_sel = 0; clk_sel_slow = 0;
    host_write(16'hFFFF);
    repeat (32) @(negedge clk);
    chk("R10 wrap count", count, 16'h0000);
    chk("R10 flag set", {15'd0, ro_flag}, 1);
    chk("R11 irq on", {15'd0, irq}, 1);
    irq_en = 0; #1;
    chk("R11 irq masked", {15'd0, irq}, 0);
    src_sel = 2'd3;
    @(negedge clk); ro_clr = 1; @(negedge clk); ro_clr = 0;
    chk("R10 flag cleared", {15'd0, ro_flag}, 0);
    host_write(16'hFFFF); host_write(16'h0000);
    chk("R10 write no flag", {15'd0, ro_flag}, 0);

    // R6 hold ignores sw_step
    host_write(16'h0042);
    @(negedge clk); sw_step = 1; repeat (5) @(negedge clk); sw_step = 0;
    chk("R6 R5 hold ignores step", count, 16'h0042);

    // R4 external
    src_sel = 2'd1;
    for (int i = 0; i < 5; i++) begin
      ext_tick = 1; repeat (3) @(negedge clk);
      ext_tick = 0; repeat (3) @(negedge clk);
    end
    chk("R4 ext edges", count, 16'h0047);
    ext_tick = 1; @(negedge clk); @(negedge clk);
    chk("R4 ext latency before", count, 16'h0047);
    @(negedge clk);
    chk("R4 ext latency after", count, 16'h0048);
    ext_tick = 0; src_sel = 2'd3; repeat (3) @(negedge clk);

    // R7 R8 disabled/enabled, R9 priority
    sync_nodata = 1; sync_clr_en = 0; @(negedge clk); sync_nodata = 0;
    chk("R7 clear disabled", count, 16'h0048);
    sync_data = 1; sync_load_en = 0; sync_word = 16'hBEEF; @(negedge clk); sync_data = 0;
    chk("R8 load disabled", count, 16'h0048);
    sync_data = 1; sync_load_en = 1; @(negedge clk); sync_data = 0;
    chk("R8 load", count, 16'hBEEF);
    sync_nodata = 1; sync_clr_en = 1; @(negedge clk); sync_nodata = 0;
    chk("R7 clear", count, 16'h0000);
    wr_en = 1; wr_data = 16'h5555; sync_nodata = 1; sync_data = 1;
    @(negedge clk); wr_en = 0;
    chk("R9 write wins", count, 16'h5555);
    @(negedge clk); sync_nodata = 0; sync_data = 0;
    chk("R9 clear beats load", count, 16'h0000);

    // R12 tag
    host_write(16'h7777);
    msg_start = 1; @(negedge clk); msg_start = 0;
    chk("R12 tag capture", tag_word, 16'h7777);
    host_write(16'h1111); @(negedge clk);
    chk("R12 tag holds", tag_word, 16'h7777);

    // random software-step mode
    src_sel = 2'd2;
    exp_c = count; exp_t = tag_word; exp_f = ro_flag;
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] nx;
      logic adv;
      wr_en = ($urandom % 12) == 0;
      wr_data = ($urandom % 2) ? 16'hFFFF - 16'($urandom % 3) : 16'($urandom);
      sync_nodata = ($urandom % 10) == 0; sync_clr_en = $urandom % 2;
      sync_data = ($urandom % 10) == 0; sync_load_en = $urandom % 2;
      sync_word = ($urandom % 2) ? 16'hFFFE : 16'($urandom);
      sw_step = $urandom % 2; msg_start = ($urandom % 4) == 0;
      ro_clr = ($urandom % 6) == 0; irq_en = $urandom % 2;
      adv = sw_step;
      nx = model_next(exp_c, wr_en, wr_data, sync_nodata, sync_clr_en, sync_data,
                      sync_load_en, sync_word, adv);
      if (msg_start) exp_t = exp_c;
      if (!wr_en && !(sync_nodata && sync_clr_en) && !(sync_data && sync_load_en)
          && adv && exp_c == 16'hFFFF) exp_f = 1;
      else if (ro_clr) exp_f = 0;
      exp_c = nx;
      @(negedge clk);
      chk("R5 R9 random count", count, exp_c);
      chk("R12 random tag", tag_word, exp_t);
      chk("R10 random flag", {15'd0, ro_flag}, {15'd0, exp_f});
      chk("R11 random irq", {15'd0, irq}, {15'd0, exp_f & irq_en});
    end
    wr_en = 0; sync_nodata = 0; sync_data = 0; sw_step = 0; msg_start = 0; ro_clr = 0;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule